// File: doc/BRIEF.md
# Parallel Byte-Load Configuration Controller

This block takes configuration bytes from a host processor over an 8-bit parallel bus and keeps them in an internal store. The host starts a write by asserting four select strobes together. Three of the strobes are active-low and one is active-high. The byte on the bus is taken when the host drops any one of the strobes. All strobe and data inputs are asynchronous. They pass through a two-stage synchronizer. The end of a write is found as a transition from "all four asserted" to "not all four asserted" between two synchronized samples.

After reset the block runs a memory-clear phase of a set number of cycles. During this phase it pulls the shared init line low and zeroes the store. At the end of the clear phase it latches the three mode pins. It then waits until no other device holds the wired-AND init line low, and after that it accepts bytes. It raises done when the expected number of bytes has been stored. At the same cycle it releases its two complementary "configuring" status pins.

In the master parallel mode, two of the select pins become outputs that carry the low address bits. In that mode the block accepts no host writes. Any write that is not accepted is counted as dropped. The stored bytes can be read back through a read port.

Top module: `cfg_load_ctrl`

## Requirements
- R1: From reset until the end of the clear phase, which lasts CLEAR_CYCLES clocks, `init_pull_low` is 1, `cfg_busy` is 1, `cfg_busy_n` is 0, `done` is 0, and every store entry reads back as zero.
- R2: The mode pins are latched once, at the last cycle of the clear phase. Changing them later has no effect on whether writes are accepted or on `addr_oe`.
- R3: After the clear phase the block stays in a waiting state for as long as `init_line` reads low (another device holds it). Writes that arrive during this wait are not stored.
- R4: A write is stored only when the synchronized strobes show `sel0_n`=0, `sel1_n`=0, `sel2_n`=0 and `sel_p`=1 together, and then any one of the four is released. Whichever strobe is released, the captured value is the data bus value at the release. If at least one strobe never reached its asserted level, nothing is stored.
- R5: With latched mode 3'b101 (peripheral), accepted bytes are stored at store indices 0, 1, 2 and onward in arrival order. `rd_data` shows the entry selected by `rd_addr`.
- R6: Right after byte number BYTE_COUNT is stored, `done` goes to 1, `cfg_busy` goes to 0 and `cfg_busy_n` goes to 1. All three then hold until reset.
- R7: Each completed write that is not stored increments `drop_count`, and the count saturates at its maximum. This covers writes during the clear phase, during the wait, after done, and in a mode other than peripheral. The store contents do not change.
- R8: With latched mode 3'b110 (master parallel), `addr_oe` is 1 once loading starts, and `addr_out` equals the two low bits of the next store index. In every other mode `addr_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_pins | input | 3 | Load mode selection, latched at the end of the clear phase |
| sel0_n | input | 1 | Write select, active low |
| sel1_n | input | 1 | Write select, active low |
| sel2_n | input | 1 | Write select, active low |
| sel_p | input | 1 | Write select, active high |
| bus_data | input | 8 | Host data bus |
| init_line | input | 1 | Sensed level of the shared wired-AND init line |
| init_pull_low | output | 1 | Enable for pulling the init line low |
| cfg_busy | output | 1 | High while configuration is in progress |
| cfg_busy_n | output | 1 | Low while configuration is in progress |
| done | output | 1 | Configuration complete |
| addr_oe | output | 1 | Output enable for the address bits (master parallel mode) |
| addr_out | output | 2 | Low two bits of the store index |
| drop_count | output | 8 | Saturating count of rejected writes |
| rd_addr | input | 4 | Store read index |
| rd_data | output | 8 | Store entry at rd_addr |

## Verification
The hardest case to reach from the ports is a write that overlaps the wait for the shared init line. The block has already left the clear phase but must still refuse the byte. The bench reaches it by holding its model of a second device on the wired-AND line after the clear phase ends. It then completes a full write and checks that `drop_count` went up and that store entry 0 is still zero. It also changes the mode pins after the latch point, puts through a partial strobe pattern, and varies which strobe is released. Together these show that the capture rule and the mode latch work as required.

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl #(
  parameter int DATA_W       = 8,
  parameter int BYTE_COUNT   = 16,
  parameter int CLEAR_CYCLES = 16,
  parameter int DROP_W       = 8,
  parameter logic [2:0] MODE_PERIPH = 3'b101,
  parameter logic [2:0] MODE_MPAR   = 3'b110,
  localparam int AW = $clog2(BYTE_COUNT),
  localparam int CW = $clog2(CLEAR_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              sel2_n,
  input  logic              sel_p,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              init_line,
  output logic              init_pull_low,
  output logic              cfg_busy,
  output logic              cfg_busy_n,
  output logic              done,
  output logic              addr_oe,
  output logic [1:0]        addr_out,
  output logic [DROP_W-1:0] drop_count,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  typedef enum logic [1:0] {ST_CLEAR, ST_WAIT, ST_LOAD, ST_DONE} st_t;

  st_t              state;
  logic [CW-1:0]    clr_cnt;
  logic [2:0]       mode_q;
  logic [AW:0]      wr_ptr;
  logic [3:0]       sel_s1, sel_s2;
  logic [DATA_W-1:0] dat_s1, dat_s2;
  logic             all_prev;
  logic [DATA_W-1:0] store [BYTE_COUNT];

  wire all_on  = (sel_s2 == 4'b1000);
  wire release_ev = all_prev && !all_on;
  wire accept  = release_ev && state == ST_LOAD && mode_q == MODE_PERIPH;
  wire reject  = release_ev && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_s1   <= 4'b0111;
      sel_s2   <= 4'b0111;
      dat_s1   <= '0;
      dat_s2   <= '0;
      all_prev <= 1'b0;
    end else begin
      sel_s1   <= {sel_p, sel2_n, sel1_n, sel0_n};
      sel_s2   <= sel_s1;
      dat_s1   <= bus_data;
      dat_s2   <= dat_s1;
      all_prev <= all_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_CLEAR;
      clr_cnt <= '0;
      mode_q  <= '0;
      wr_ptr  <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == CW'(CLEAR_CYCLES - 1)) begin
            mode_q <= mode_pins;
            state  <= ST_WAIT;
          end
        end
        ST_WAIT: if (init_line) state <= ST_LOAD;
        ST_LOAD: if (accept) begin
          wr_ptr <= wr_ptr + 1'b1;
          if (wr_ptr == (AW+1)'(BYTE_COUNT - 1)) state <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_CLEAR) begin
      for (int i = 0; i < BYTE_COUNT; i++) store[i] <= '0;
    end else if (accept) begin
      store[wr_ptr[AW-1:0]] <= dat_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        drop_count <= '0;
    else if (reject && drop_count != '1) drop_count <= drop_count + 1'b1;
  end

  assign init_pull_low = (state == ST_CLEAR);
  assign done          = (state == ST_DONE);
  assign cfg_busy      = !done;
  assign cfg_busy_n    = done;
  assign addr_oe       = (state == ST_LOAD) && (mode_q == MODE_MPAR);
  assign addr_out      = wr_ptr[1:0];
  assign rd_data       = store[rd_addr];

endmodule

// File: rtl/cfg_load_ctrl_chk.sv
module cfg_load_ctrl_chk #(
  parameter int BYTE_COUNT = 16,
  parameter int DROP_W     = 8,
  parameter logic [2:0] MODE_MPAR = 3'b110,
  localparam int AW = $clog2(BYTE_COUNT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        state,
  input logic [2:0]        mode_q,
  input logic [AW:0]       wr_ptr,
  input logic              init_pull_low,
  input logic              cfg_busy,
  input logic              done,
  input logic              addr_oe,
  input logic [DROP_W-1:0] drop_count
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0; else past_ok <= 1'b1;

  AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    init_pull_low |-> (cfg_busy && !done)); // R1
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(state) != 2'd0) |-> $stable(mode_q)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= (AW+1)'(BYTE_COUNT)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_ptr != $past(wr_ptr)) |-> wr_ptr == $past(wr_ptr) + 1'b1); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R6
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wr_ptr == (AW+1)'(BYTE_COUNT)); // R6
  AST_DROP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> drop_count >= $past(drop_count)); // R7
  AST_ADDR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> mode_q == MODE_MPAR); // R8
endmodule

bind cfg_load_ctrl cfg_load_ctrl_chk #(
  .BYTE_COUNT(BYTE_COUNT), .DROP_W(DROP_W), .MODE_MPAR(MODE_MPAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .mode_q(mode_q), .wr_ptr(wr_ptr),
  .init_pull_low(init_pull_low), .cfg_busy(cfg_busy), .done(done),
  .addr_oe(addr_oe), .drop_count(drop_count)
);

// File: tb/sim_cfg_load_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_load_ctrl;
  localparam int NB = 16;
  localparam int CLR = 16;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode_pins = 3'b101;
  logic s0n = 1, s1n = 1, s2n = 1, sp = 0;
  logic [7:0] bus = 0;
  logic ext_hold = 1;
  logic init_pull_low, cfg_busy, cfg_busy_n, done, addr_oe;
  logic [1:0] addr_out;
  logic [7:0] drop_count, rd_data;
  logic [3:0] rd_addr = 0;
  wire init_line = !(init_pull_low || ext_hold);

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic mon_go = 0, mon_fin = 0;

  always #4 clk = ~clk;

  cfg_load_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
    .sel0_n(s0n), .sel1_n(s1n), .sel2_n(s2n), .sel_p(sp),
    .bus_data(bus), .init_line(init_line), .init_pull_low(init_pull_low),
    .cfg_busy(cfg_busy), .cfg_busy_n(cfg_busy_n), .done(done),
    .addr_oe(addr_oe), .addr_out(addr_out), .drop_count(drop_count),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, int which, bit stored);
    @(negedge clk);
    bus = d; s0n = 0; s1n = 0; s2n = 0; sp = 1;
    cyc(3);
    case (which)
      0: s0n = 1;
      1: s1n = 1;
      2: s2n = 1;
      default: sp = 0;
    endcase
    cyc(4);
    s0n = 1; s1n = 1; s2n = 1; sp = 0;
    cyc(3);
    if (stored) exp_q.push_back(d);
  endtask

  initial begin : monitor
    wait (mon_go);
    for (int i = 0; i < NB; i++) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      rd_addr = 4'(i);
      #1;
      chk("R5 store", rd_data, e);
    end
    mon_fin = 1;
  end

  initial begin : watchdog
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    cyc(2); rst_n = 1;
    cyc(2);
    chk("R1 init pull", init_pull_low, 1);
    chk("R1 busy", cfg_busy, 1);
    chk("R1 busy_n", cfg_busy_n, 0);
    chk("R1 done", done, 0);
    wr(8'hEE, 0, 0);
    chk("R7 drop in clear", drop_count, 1);
    rd_addr = 0; #1;
    chk("R1 cleared store", rd_data, 0);
    cyc(CLR);
    chk("R3 clear ended", init_pull_low, 0);
    mode_pins = 3'b000;
    wr(8'hDD, 3, 0);
    chk("R3 drop while held", drop_count, 2);
    rd_addr = 0; #1;
    chk("R3 nothing stored", rd_data, 0);
    chk("R8 oe in peripheral", addr_oe, 0);
    ext_hold = 0;
    cyc(3);
    @(negedge clk);
    bus = 8'h77; s0n = 0; s1n = 0; s2n = 1; sp = 1;
    cyc(4); s0n = 1; sp = 0; cyc(4);
    rd_addr = 0; #1;
    chk("R4 partial not stored", rd_data, 0);
    chk("R4 partial not dropped", drop_count, 2);
    for (int i = 0; i < NB; i++) begin
      wr(8'(8'h3C ^ (i * 37)), i % 4, 1);
      if (i == 0) begin
        rd_addr = 0; #1;
        chk("R4 first capture", rd_data, 8'h3C);
        chk("R2 late mode ignored", done, 0);
      end
      if (i == NB - 2) chk("R6 not done early", done, 0);
    end
    chk("R6 done", done, 1);
    chk("R6 busy released", cfg_busy, 0);
    chk("R6 busy_n released", cfg_busy_n, 1);
    mon_go = 1;
    wait (mon_fin);
    wr(8'h99, 1, 0);
    chk("R7 drop after done", drop_count, 3);
    rd_addr = 0; #1;
    chk("R7 store kept", rd_data, 8'h3C);
    chk("R6 done held", done, 1);

    rst_n = 0; mode_pins = 3'b110; ext_hold = 0;
    cyc(2); rst_n = 1;
    cyc(CLR + 4);
    chk("R8 oe master", addr_oe, 1);
    chk("R8 addr bits", addr_out, 0);
    wr(8'h55, 2, 0);
    chk("R8 master drops write", drop_count, 1);
    chk("R8 not done", done, 0);
    rd_addr = 0; #1;
    chk("R8 store empty", rd_data, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule